// File: doc/BRIEF.md
# I2C-over-AUX Segmenting Bridge

This block takes a list of I2C messages and turns each one into a run of auxiliary-channel I2C requests. Each request carries at most 16 bytes. A host starts a run by pulsing `start_i` with the number of messages. The bridge then pulls one descriptor per message (7-bit target address, read/write flag, byte length from 0 to 255) from a valid/ready stream. For each segment it raises a request toward an auxiliary-channel sequencer.

Every request names the message index and the byte offset into that message's buffer. The sequencer can therefore fetch write bytes from that offset, or store returned read bytes there. The bridge keeps the I2C transaction open with a middle-of-transaction flag, which stays set until the final segment of the final message.

The sequencer answers each request with a single response beat carrying a result code, where zero means success. A nonzero code ends the run at once. When the run ends, the bridge pulses `done_o` and holds the status outputs (error flag, error code, completed message count) until the next start.

Top module: `i2c_aux_seg_bridge`

## Requirements
- R1: A message of L bytes is issued as segments of min(remaining, 16) bytes, in order, until no bytes remain. No other requests are made.
- R2: `req_rd_o` is 1 on every segment of a message whose descriptor read flag is 1, and 0 on every segment of a message whose read flag is 0.
- R3: `req_mot_o` is 1 when the message is not the last of the run, or when more than 16 bytes remain before the segment. Otherwise it is 0, so only the last segment of the last message closes the transaction.
- R4: `req_addr_o` equals the 7-bit address of the message's descriptor on each of its segments.
- R5: A response with a nonzero code stops the run: no further request is raised, and `done_o` pulses in the cycle after that response. `done_err_o` is then 1, `done_code_o` equals the code, and `done_count_o` equals the number of messages fully completed before the failing one.
- R6: A run in which every response code is 0 ends with a one-cycle `done_o` pulse. `done_err_o` is then 0, `done_code_o` is 0 and `done_count_o` equals the requested message count.
- R7: `req_offset_o` is 0 on a message's first segment and grows by each segment's length. `req_msg_o` is the zero-based index of the message.
- R8: A descriptor of length 0 is consumed without any request and counts as a completed message.
- R9: A start with a message count of 0 consumes no descriptor, raises no request, and ends with success and a count of 0.
- R10: While reset is applied and while idle, `busy_o`, `req_valid_o`, `desc_ready_o` and `done_o` are 0.
- R11: `start_i` is ignored while a run is in progress; the request stream and final count are unchanged.
- R12: Once `req_valid_o` is raised, it and all request fields hold steady until `req_ready_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run (idle only) |
| msg_count_i | input | CNT_W | Messages in the run |
| busy_o | output | 1 | Run in progress |
| desc_valid_i | input | 1 | Descriptor present |
| desc_ready_o | output | 1 | Descriptor accepted this cycle when valid |
| desc_addr_i | input | ADDR_W | Target I2C address |
| desc_rd_i | input | 1 | 1 = read message |
| desc_len_i | input | LEN_W | Message length in bytes |
| req_valid_o | output | 1 | Segment request present |
| req_ready_i | input | 1 | Sequencer takes the request |
| req_addr_o | output | ADDR_W | Target address of the segment |
| req_rd_o | output | 1 | 1 = I2C read request, 0 = I2C write request |
| req_mot_o | output | 1 | Middle-of-transaction flag |
| req_len_o | output | SEG_W | Segment length, 1 to 16 |
| req_msg_o | output | CNT_W | Message index |
| req_offset_o | output | LEN_W | Byte offset into the message buffer |
| rsp_valid_i | input | 1 | Response beat for the outstanding request |
| rsp_code_i | input | CODE_W | Result, 0 = success |
| done_o | output | 1 | One-cycle end-of-run pulse |
| done_err_o | output | 1 | Run ended on an error |
| done_code_o | output | CODE_W | Error code of the failing segment |
| done_count_o | output | CNT_W | Messages completed |

## Verification
The bench aims at the exact 16/17-byte boundary and at a full 255-byte message. A bridge with an off-by-one in its length compare would emit a stray zero-length segment or drop the last byte, and it would mis-set the transaction flag on the 16-byte segment. Zero-length messages sit in the middle and at the end of a list. A bridge that issued a request for them, or failed to count them, would change both the request stream and the final count. Errors are injected in the first and later messages, mid-message. A bridge that kept going or reported the wrong count would show extra requests or a wrong status. A stray start pulse arrives mid-run, and the request ready is throttled, to expose state reloaded during a run or fields that change before acceptance.

// File: rtl/i2c_aux_seg_pkg.sv
package i2c_aux_seg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } seg_state_e;

  // bytes taken by the next segment
  function automatic int unsigned seg_take(int unsigned rem, int unsigned cap);
    return (rem > cap) ? cap : rem;
  endfunction

  // true when the next segment empties the message
  function automatic logic seg_is_last(int unsigned rem, int unsigned cap);
    return rem <= cap;
  endfunction

  // transaction stays open if anything at all follows this segment
  function automatic logic seg_keep_open(int unsigned rem, int unsigned cap, logic more_msgs);
    return more_msgs || (rem > cap);
  endfunction

endpackage

// File: rtl/i2c_aux_seg_msgcnt.sv
module i2c_aux_seg_msgcnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_msg_o,
  output logic             total_zero_o
);
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] total_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      total_q <= '0;
    end else if (load_i) begin
      idx_q   <= '0;
      total_q <= total_i;
    end else if (step_i) begin
      idx_q <= idx_q + CNT_W'(1);
    end
  end

  assign idx_o        = idx_q;
  assign last_msg_o   = (idx_q + CNT_W'(1)) == total_q;
  assign total_zero_o = (total_i == '0);
endmodule

// File: rtl/i2c_aux_seg_cursor.sv
module i2c_aux_seg_cursor
  import i2c_aux_seg_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int ADDR_W  = 7,
  parameter int SEG_MAX = 16,
  parameter int SEG_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              adv_i,
  output logic [LEN_W-1:0]  rem_o,
  output logic [LEN_W-1:0]  off_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic              last_seg_o
);
  logic [LEN_W-1:0]  rem_q;
  logic [LEN_W-1:0]  off_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;

  assign seg_o      = SEG_W'(seg_take(32'(rem_q), SEG_MAX));
  assign last_seg_o = seg_is_last(32'(rem_q), SEG_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      off_q  <= '0;
      addr_q <= '0;
      rd_q   <= 1'b0;
    end else if (load_i) begin
      rem_q  <= len_i;
      off_q  <= '0;
      addr_q <= addr_i;
      rd_q   <= rd_i;
    end else if (adv_i) begin
      rem_q <= rem_q - LEN_W'(seg_o);
      off_q <= off_q + LEN_W'(seg_o);
    end
  end

  assign rem_o  = rem_q;
  assign off_o  = off_q;
  assign addr_o = addr_q;
  assign rd_o   = rd_q;
endmodule

// File: rtl/i2c_aux_seg_fsm.sv
module i2c_aux_seg_fsm
  import i2c_aux_seg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic total_zero_i,
  input  logic desc_valid_i,
  input  logic desc_empty_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  input  logic rsp_fail_i,
  input  logic last_seg_i,
  input  logic last_msg_i,
  output logic load_cnt_o,
  output logic load_cur_o,
  output logic adv_o,
  output logic step_o,
  output logic fin_err_o,
  output logic busy_o,
  output logic desc_ready_o,
  output logic req_valid_o,
  output logic awaiting_o,
  output logic done_o
);
  seg_state_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    load_cnt_o = 1'b0;
    load_cur_o = 1'b0;
    adv_o      = 1'b0;
    step_o     = 1'b0;
    fin_err_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load_cnt_o = 1'b1;
          st_d       = total_zero_i ? ST_DONE : ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (desc_valid_i) begin
          if (desc_empty_i) begin
            step_o = 1'b1;
            st_d   = last_msg_i ? ST_DONE : ST_FETCH;
          end else begin
            load_cur_o = 1'b1;
            st_d       = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (req_ready_i) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid_i) begin
          if (rsp_fail_i) begin
            fin_err_o = 1'b1;
            st_d      = ST_DONE;
          end else begin
            adv_o = 1'b1;
            if (last_seg_i) begin
              step_o = 1'b1;
              st_d   = last_msg_i ? ST_DONE : ST_FETCH;
            end else begin
              st_d = ST_ISSUE;
            end
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign desc_ready_o = (st_q == ST_FETCH);
  assign req_valid_o  = (st_q == ST_ISSUE);
  assign awaiting_o   = (st_q == ST_WAIT);
  assign done_o       = (st_q == ST_DONE);
endmodule

// File: rtl/i2c_aux_seg_bridge.sv
module i2c_aux_seg_bridge
  import i2c_aux_seg_pkg::*;
#(
  parameter int MAX_MSGS = 16,
  parameter int LEN_W    = 8,
  parameter int ADDR_W   = 7,
  parameter int SEG_MAX  = 16,
  parameter int CODE_W   = 2,
  localparam int CNT_W   = $clog2(MAX_MSGS + 1),
  localparam int SEG_W   = $clog2(SEG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  msg_count_i,
  output logic              busy_o,
  input  logic              desc_valid_i,
  output logic              desc_ready_o,
  input  logic [ADDR_W-1:0] desc_addr_i,
  input  logic              desc_rd_i,
  input  logic [LEN_W-1:0]  desc_len_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              req_rd_o,
  output logic              req_mot_o,
  output logic [SEG_W-1:0]  req_len_o,
  output logic [CNT_W-1:0]  req_msg_o,
  output logic [LEN_W-1:0]  req_offset_o,
  input  logic              rsp_valid_i,
  input  logic [CODE_W-1:0] rsp_code_i,
  output logic              done_o,
  output logic              done_err_o,
  output logic [CODE_W-1:0] done_code_o,
  output logic [CNT_W-1:0]  done_count_o
);
  // named internal events, also watched by the checker
  logic             load_cnt, load_cur, adv, step, fin_err;
  logic             total_zero, last_msg, last_seg, awaiting_rsp;
  logic [LEN_W-1:0] seg_rem;
  logic [CNT_W-1:0] msg_idx;

  i2c_aux_seg_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .total_zero_i (total_zero),
    .desc_valid_i (desc_valid_i),
    .desc_empty_i (desc_len_i == '0),
    .req_ready_i  (req_ready_i),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_fail_i   (rsp_code_i != '0),
    .last_seg_i   (last_seg),
    .last_msg_i   (last_msg),
    .load_cnt_o   (load_cnt),
    .load_cur_o   (load_cur),
    .adv_o        (adv),
    .step_o       (step),
    .fin_err_o    (fin_err),
    .busy_o       (busy_o),
    .desc_ready_o (desc_ready_o),
    .req_valid_o  (req_valid_o),
    .awaiting_o   (awaiting_rsp),
    .done_o       (done_o)
  );

  i2c_aux_seg_msgcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_cnt),
    .total_i      (msg_count_i),
    .step_i       (step),
    .idx_o        (msg_idx),
    .last_msg_o   (last_msg),
    .total_zero_o (total_zero)
  );

  i2c_aux_seg_cursor #(
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .SEG_MAX(SEG_MAX), .SEG_W(SEG_W)
  ) u_cur (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_cur),
    .len_i      (desc_len_i),
    .addr_i     (desc_addr_i),
    .rd_i       (desc_rd_i),
    .adv_i      (adv),
    .rem_o      (seg_rem),
    .off_o      (req_offset_o),
    .addr_o     (req_addr_o),
    .rd_o       (req_rd_o),
    .seg_o      (req_len_o),
    .last_seg_o (last_seg)
  );

  assign req_mot_o    = seg_keep_open(32'(seg_rem), SEG_MAX, !last_msg);
  assign req_msg_o    = msg_idx;
  assign done_count_o = msg_idx;

  logic              err_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n || load_cnt) begin
      err_q  <= 1'b0;
      code_q <= '0;
    end else if (fin_err) begin
      err_q  <= 1'b1;
      code_q <= rsp_code_i;
    end
  end

  assign done_err_o  = err_q;
  assign done_code_o = code_q;
endmodule

// File: rtl/i2c_aux_seg_chk.sv
module i2c_aux_seg_chk #(
  parameter int LEN_W   = 8,
  parameter int SEG_MAX = 16,
  parameter int SEG_W   = 5,
  parameter int CNT_W   = 5,
  parameter int CODE_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              desc_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_mot,
  input logic              req_rd,
  input logic [SEG_W-1:0]  req_len,
  input logic [LEN_W-1:0]  req_offset,
  input logic [CNT_W-1:0]  req_msg,
  input logic              rsp_valid,
  input logic [CODE_W-1:0] rsp_code,
  input logic              done,
  input logic              done_err,
  input logic [LEN_W-1:0]  rem,
  input logic              awaiting
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_len) && $stable(req_offset)
      && $stable(req_mot) && $stable(req_rd) && $stable(req_msg));

  assert_seg_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (32'(req_len) == 32'(rem) || 32'(req_len) == SEG_MAX));

  assert_open_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (32'(rem) > SEG_MAX) |-> req_mot);

  assert_err_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    awaiting && rsp_valid && (rsp_code != '0) |=> done && done_err && !req_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !desc_ready && !done);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
endmodule

bind i2c_aux_seg_bridge i2c_aux_seg_chk #(
  .LEN_W(LEN_W), .SEG_MAX(SEG_MAX), .SEG_W(SEG_W), .CNT_W(CNT_W), .CODE_W(CODE_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy_o),
  .desc_ready (desc_ready_o),
  .req_valid  (req_valid_o),
  .req_ready  (req_ready_i),
  .req_mot    (req_mot_o),
  .req_rd     (req_rd_o),
  .req_len    (req_len_o),
  .req_offset (req_offset_o),
  .req_msg    (req_msg_o),
  .rsp_valid  (rsp_valid_i),
  .rsp_code   (rsp_code_i),
  .done       (done_o),
  .done_err   (done_err_o),
  .rem        (seg_rem),
  .awaiting   (awaiting_rsp)
);

// File: tb/i2c_aux_seg_bridge_tb.sv
module i2c_aux_seg_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [4:0] msg_count_i = '0;
  logic       busy_o;
  logic       desc_valid_i = 1'b0;
  logic       desc_ready_o;
  logic [6:0] desc_addr_i = '0;
  logic       desc_rd_i = 1'b0;
  logic [7:0] desc_len_i = '0;
  logic       req_valid_o;
  logic       req_ready_i = 1'b0;
  logic [6:0] req_addr_o;
  logic       req_rd_o, req_mot_o;
  logic [4:0] req_len_o;
  logic [4:0] req_msg_o;
  logic [7:0] req_offset_o;
  logic       rsp_valid_i = 1'b0;
  logic [1:0] rsp_code_i = '0;
  logic       done_o, done_err_o;
  logic [1:0] done_code_o;
  logic [4:0] done_count_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_aux_seg_bridge dut_i (.*);

  typedef struct { int msg; int off; int len; bit mot; bit rd; int addr; } seg_t;
  seg_t exp_q[$];
  int   m_len[8];
  int   m_addr[8];
  bit   m_rd[8];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   exp_err;
  int   exp_code;
  int   exp_count;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // reference: list every segment the requirements call for
  task automatic build(int n, int err_at, int code);
    int k = 0;
    exp_q.delete();
    exp_err = 1'b0; exp_code = 0; exp_count = n;
    for (int m = 0; m < n; m++) begin
      int rem = m_len[m];
      int off = 0;
      while (rem > 0) begin
        seg_t s;
        s.msg = m; s.off = off; s.len = (rem > 16) ? 16 : rem;
        s.mot = (m < n - 1) || (rem > 16); s.rd = m_rd[m]; s.addr = m_addr[m];
        if (err_at < 0 || k <= err_at) exp_q.push_back(s);
        if (k == err_at) begin exp_err = 1'b1; exp_code = code; exp_count = m; end
        k++;
        rem -= s.len; off += s.len;
      end
    end
  endtask

  task automatic run_test(string name, int n, int err_at, int code, int lat, bit throttle, bit poke);
    int  dptr = 0, pend = -1, rsp_cnt = 0, cyc = 0;
    bit  d_fire = 0, r_fire = 0, fin = 0;
    build(n, err_at, code);
    @(negedge clk);
    start_i = 1'b1; msg_count_i = 5'(n);
    while (!fin) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
      if (poke && (cyc == 4 || cyc == 9)) begin
        start_i = 1'b1; msg_count_i = 5'd3; // R11 stray start mid-run
      end
      if (d_fire) dptr++;
      if (r_fire) pend = lat;
      rsp_valid_i = 1'b0;
      if (done_o) begin
        string t = exp_err ? "R5" : (poke ? "R11" : "R6");
        chk(done_err_o == exp_err, {name, " ", t, " err flag"}, int'(done_err_o), int'(exp_err));
        chk(int'(done_code_o) == exp_code, {name, " ", t, " code"}, int'(done_code_o), exp_code);
        chk(int'(done_count_o) == exp_count, {name, " ", t, " count"}, int'(done_count_o), exp_count);
        chk(exp_q.size() == 0, {name, " R1 missing segments"}, exp_q.size(), 0);
        if (n == 0) chk(dptr == 0, {name, " R9 descriptors taken"}, dptr, 0);
        fin = 1;
      end
      if (cyc > 3000) begin
        chk(1'b0, {name, " watchdog"}, cyc, 3000);
        fin = 1;
      end
      desc_valid_i = (dptr < n) && !fin;
      desc_addr_i  = (dptr < n) ? 7'(m_addr[dptr]) : '0;
      desc_rd_i    = (dptr < n) ? m_rd[dptr] : 1'b0;
      desc_len_i   = (dptr < n) ? 8'(m_len[dptr]) : '0;
      req_ready_i  = throttle ? (cyc % 3 == 0) : 1'b1;
      if (pend == 0) begin
        rsp_valid_i = 1'b1;
        rsp_code_i  = (rsp_cnt == err_at) ? 2'(code) : 2'd0;
        rsp_cnt++;
        pend = -1;
      end else if (pend > 0) begin
        pend--;
      end
      d_fire = desc_valid_i && desc_ready_o;
      r_fire = req_valid_o && req_ready_i && !fin;
      if (r_fire) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, {name, " R1 extra request"}, int'(req_len_o), 0);
        end else begin
          seg_t s = exp_q.pop_front();
          chk(int'(req_len_o) == s.len, {name, " R1 seg length"}, int'(req_len_o), s.len);
          chk(req_rd_o == s.rd, {name, " R2 read flag"}, int'(req_rd_o), int'(s.rd));
          chk(req_mot_o == s.mot, {name, " R3 mot flag"}, int'(req_mot_o), int'(s.mot));
          chk(int'(req_addr_o) == s.addr, {name, " R4 address"}, int'(req_addr_o), s.addr);
          chk(int'(req_offset_o) == s.off, {name, " R7 offset"}, int'(req_offset_o), s.off);
          chk(int'(req_msg_o) == s.msg, {name, " R7 msg index"}, int'(req_msg_o), s.msg);
        end
      end
    end
    desc_valid_i = 1'b0;
    rsp_valid_i  = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy_o && !req_valid_o && !desc_ready_o && !done_o, "R10 reset outputs",
        int'({busy_o, req_valid_o, desc_ready_o, done_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !req_valid_o && !desc_ready_o, "R10 idle outputs",
        int'({busy_o, req_valid_o, desc_ready_o}), 0);

    m_len[0] = 5;  m_addr[0] = 'h50; m_rd[0] = 0;
    run_test("single write", 1, -1, 0, 0, 0, 0);

    m_len[0] = 40; m_addr[0] = 'h37; m_rd[0] = 1;
    run_test("long read", 1, -1, 0, 2, 0, 0);

    m_len[0] = 16; m_addr[0] = 'h21; m_rd[0] = 0;
    m_len[1] = 17; m_addr[1] = 'h22; m_rd[1] = 1;
    run_test("boundary pair", 2, -1, 0, 1, 1, 0);

    m_len[0] = 3;  m_addr[0] = 'h10; m_rd[0] = 0;
    m_len[1] = 0;  m_addr[1] = 'h11; m_rd[1] = 1; // R8 zero-length mid list
    m_len[2] = 20; m_addr[2] = 'h12; m_rd[2] = 1;
    run_test("R8 empty middle", 3, -1, 0, 0, 0, 0);

    m_len[0] = 4;  m_addr[0] = 'h44; m_rd[0] = 0;
    m_len[1] = 0;  m_addr[1] = 'h45; m_rd[1] = 0; // R8 zero-length last
    run_test("R8 empty last", 2, -1, 0, 0, 0, 0);

    run_test("R9 zero count", 0, -1, 0, 0, 0, 0);

    m_len[0] = 40; m_addr[0] = 'h3a; m_rd[0] = 1;
    run_test("R5 error mid message", 1, 1, 2, 1, 0, 0);

    m_len[0] = 5;  m_addr[0] = 'h60; m_rd[0] = 0;
    m_len[1] = 5;  m_addr[1] = 'h61; m_rd[1] = 1;
    m_len[2] = 9;  m_addr[2] = 'h62; m_rd[2] = 0;
    run_test("R5 error second message", 3, 1, 1, 0, 1, 0);

    m_len[0] = 255; m_addr[0] = 'h7f; m_rd[0] = 0;
    run_test("max length", 1, -1, 0, 0, 0, 0);

    m_len[0] = 33; m_addr[0] = 'h05; m_rd[0] = 1;
    m_len[1] = 2;  m_addr[1] = 'h06; m_rd[1] = 0;
    run_test("R11 stray start", 2, -1, 0, 3, 1, 1);

    @(negedge clk);
    @(negedge clk);
    chk(!busy_o && !done_o, "R10 idle after runs", int'({busy_o, done_o}), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL global watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule